// File: doc/BRIEF.md
# Reset Supervisor Controller with Watchdog

This block is the digital core of a system reset supervisor. It drives one active-low system reset from three kinds of source: a manual reset request, a set of per-channel supply fault flags (under-voltage and over-voltage, each gated by its own enable bit), and a watchdog that expects regular falling edges on a kick input. Whenever any source is active, the reset stays asserted. After the last source clears, the reset is stretched by a programmable number of clock cycles and only then released.

A second output, the sequencer hold, tells an external power-up sequencer to pause. Only a manual reset or the block's own synchronous reset raises the hold. It stays up until the reset output releases, so an interrupted power-up cascade can continue from its current step. The analog comparators, threshold generation and the open-drain pad sit outside this block. Every flag and the manual reset arrive as synchronised digital levels.

Top module: `rsv_top`

## Requirements
- R1: While `srst` is high and after it falls, `sup_rst_n` is 0 and `seq_hold` is 1. Both change (to 1 and 0) at the clock edge that comes `rst_tmo` edges after the last edge that sampled `srst` high.
- R2: An edge that samples `man_rst_n` low drives `sup_rst_n` to 0 and `seq_hold` to 1 from that edge, and both hold for as long as `man_rst_n` stays low.
- R3: `sup_rst_n` returns to 1 exactly `rst_tmo` edges after the last edge that sampled any source active, or one edge later when `rst_tmo` is 0.
- R4: A source that becomes active again while the stretch is counting down reloads the count, so the release moves to `rst_tmo` edges after that new activity.
- R5: A falling edge on `wd_kick` (sampled high on one edge, low on the next) restarts the watchdog. Kicks spaced closer than `wd_tmo` cycles keep `sup_rst_n` at 1.
- R6: If `wd_tmo` edges pass after a watchdog restart with no falling edge on `wd_kick`, `sup_rst_n` goes to 0 at that edge and is then stretched as in R3.
- R7: Holding `wd_kick` at a steady low level is not a kick. The watchdog expires `wd_tmo` edges after the edge that saw the fall.
- R8: Bit i of `uv_flag` asserts the reset at the next edge only when bit i of `uv_en` is 1. A flag on a disabled channel leaves `sup_rst_n` at 1.
- R9: Bit i of `ov_flag` asserts the reset only when bit i of `ov_en` is 1. The over-voltage enables are separate from the under-voltage enables.
- R10: `seq_hold` is 1 only while `sup_rst_n` is 0, and only manual reset or `srst` raises it. A reset caused only by a supply fault or by the watchdog leaves `seq_hold` at 0.
- R11: The watchdog count restarts at every release of the reset, so the next expiry with no kicks lands `wd_tmo` edges after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high block reset |
| man_rst_n | input | 1 | Manual reset request, active low |
| wd_kick | input | 1 | Watchdog kick; a falling edge restarts the watchdog |
| uv_flag | input | NCH | Under-voltage flags, one per channel |
| ov_flag | input | NCH | Over-voltage flags, one per channel |
| uv_en | input | NCH | Per-channel enable for under-voltage reset |
| ov_en | input | NCH | Per-channel enable for over-voltage reset |
| rst_tmo | input | TW | Reset stretch length in clock cycles |
| wd_tmo | input | WW | Watchdog period in clock cycles |
| sup_rst_n | output | 1 | Supervised system reset, active low |
| seq_hold | output | 1 | Pause request to the power-up sequencer |

## Verification
Manual reset is applied both as a multi-cycle hold and as a single-cycle pulse with a zero stretch. This separates the reload-while-active behaviour from the minimum one-edge release. Supply flags are raised on enabled and disabled channels. A flag on a channel whose enable sits in the other polarity's mask shows that the two enable sets are decoded separately. A second fault during a countdown tells a reloading counter from one that only starts once. The watchdog is driven three ways: with no kicks at all, held low after a single fall, and toggled faster than its period. Together these separate edge detection from level detection, and show that the count restarts at each release.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Sources that can hold the supervised reset asserted.
    typedef struct packed {
        logic manual;   // manual request or block reset
        logic supply;   // enabled supply fault
        logic wdog;     // watchdog expiry
    } rsv_src_t;

    function automatic logic src_any(input rsv_src_t s);
        return s.manual | s.supply | s.wdog;
    endfunction

endpackage

// File: rtl/rsv_chan_mask.sv
module rsv_chan_mask #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] uv_flag,
    input  logic [NCH-1:0] ov_flag,
    input  logic [NCH-1:0] uv_en,
    input  logic [NCH-1:0] ov_en,
    output logic           fault_any
);

    logic [NCH-1:0] hit;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        // each channel qualifies its own two fault polarities
        assign hit[ch] = (uv_flag[ch] & uv_en[ch]) | (ov_flag[ch] & ov_en[ch]);
    end

    assign fault_any = |hit;

endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
    parameter int WW = 24
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          kick,
    input  logic          hold_clr,
    input  logic [WW-1:0] tmo,
    output logic          expire
);

    typedef struct packed {
        logic          kick_q;
        logic [WW-1:0] cnt;
    } wd_state_t;

    wd_state_t st_q, st_d;

    logic          fall;
    logic          restart;
    logic [WW-1:0] limit;

    always_comb begin
        st_d    = st_q;
        fall    = st_q.kick_q & ~kick;
        restart = hold_clr | fall;
        limit   = (tmo == '0) ? '0 : tmo - WW'(1);
        expire  = 1'b0;

        st_d.kick_q = kick;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit) begin
            expire   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + WW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q.kick_q <= 1'b1;   // no edge seen out of reset
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch
    import rsv_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          srst,
    input  rsv_src_t      src,
    input  logic [TW-1:0] tmo,
    output logic          asserted,
    output logic          hold,
    output logic [TW-1:0] cnt
);

    typedef struct packed {
        logic          asrt;
        logic          hold;
        logic [TW-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (src_any(src)) begin
            st_d.asrt = 1'b1;
            st_d.cnt  = tmo;
            if (src.manual) begin
                st_d.hold = 1'b1;
            end
        end else if (st_q.asrt) begin
            if (st_q.cnt <= TW'(1)) begin
                st_d.asrt = 1'b0;
                st_d.hold = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q.asrt <= 1'b1;
            st_q.hold <= 1'b1;
            st_q.cnt  <= tmo;
        end else begin
            st_q <= st_d;
        end
    end

    assign asserted = st_q.asrt;
    assign hold     = st_q.hold;
    assign cnt      = st_q.cnt;

endmodule

// File: rtl/rsv_top.sv
module rsv_top
    import rsv_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 16,
    parameter int WW  = 24
) (
    input  logic           clk,
    input  logic           srst,
    input  logic           man_rst_n,
    input  logic           wd_kick,
    input  logic [NCH-1:0] uv_flag,
    input  logic [NCH-1:0] ov_flag,
    input  logic [NCH-1:0] uv_en,
    input  logic [NCH-1:0] ov_en,
    input  logic [TW-1:0]  rst_tmo,
    input  logic [WW-1:0]  wd_tmo,
    output logic           sup_rst_n,
    output logic           seq_hold
);

    logic          fault_any;
    logic          wd_expire;
    logic          asserted;
    logic [TW-1:0] tmo_cnt;
    rsv_src_t      src;

    rsv_chan_mask #(.NCH(NCH)) u_mask (
        .uv_flag   (uv_flag),
        .ov_flag   (ov_flag),
        .uv_en     (uv_en),
        .ov_en     (ov_en),
        .fault_any (fault_any)
    );

    rsv_watchdog #(.WW(WW)) u_wdog (
        .clk      (clk),
        .srst     (srst),
        .kick     (wd_kick),
        .hold_clr (asserted),
        .tmo      (wd_tmo),
        .expire   (wd_expire)
    );

    always_comb begin
        src.manual = ~man_rst_n;
        src.supply = fault_any;
        src.wdog   = wd_expire;
    end

    rsv_stretch #(.TW(TW)) u_stretch (
        .clk      (clk),
        .srst     (srst),
        .src      (src),
        .tmo      (rst_tmo),
        .asserted (asserted),
        .hold     (seq_hold),
        .cnt      (tmo_cnt)
    );

    assign sup_rst_n = ~asserted;

endmodule

// File: rtl/rsv_top_chk.sv
module rsv_top_chk #(
    parameter int NCH = 4,
    parameter int TW  = 16
) (
    input logic           clk,
    input logic           srst,
    input logic           man_rst_n,
    input logic [NCH-1:0] uv_flag,
    input logic [NCH-1:0] ov_flag,
    input logic [NCH-1:0] uv_en,
    input logic [NCH-1:0] ov_en,
    input logic [TW-1:0]  rst_tmo,
    input logic           sup_rst_n,
    input logic           seq_hold,
    input logic           wd_expire,
    input logic [TW-1:0]  tmo_cnt
);

    p_manual_r2: assert property (@(posedge clk) disable iff (srst)
        !man_rst_n |=> (!sup_rst_n && seq_hold));

    p_uv_gate_r8: assert property (@(posedge clk) disable iff (srst)
        (|(uv_flag & uv_en)) |=> !sup_rst_n);

    p_ov_gate_r9: assert property (@(posedge clk) disable iff (srst)
        (|(ov_flag & ov_en)) |=> !sup_rst_n);

    p_reload_r4: assert property (@(posedge clk) disable iff (srst)
        (!man_rst_n || (|(uv_flag & uv_en)) || (|(ov_flag & ov_en)))
        |=> (tmo_cnt == $past(rst_tmo)));

    p_wdog_rst_r6: assert property (@(posedge clk) disable iff (srst)
        wd_expire |=> !sup_rst_n);

    p_hold_in_rst_r10: assert property (@(posedge clk) disable iff (srst)
        seq_hold |-> !sup_rst_n);

endmodule

bind rsv_top rsv_top_chk #(.NCH(NCH), .TW(TW)) u_chk (
    .clk       (clk),
    .srst      (srst),
    .man_rst_n (man_rst_n),
    .uv_flag   (uv_flag),
    .ov_flag   (ov_flag),
    .uv_en     (uv_en),
    .ov_en     (ov_en),
    .rst_tmo   (rst_tmo),
    .sup_rst_n (sup_rst_n),
    .seq_hold  (seq_hold),
    .wd_expire (wd_expire),
    .tmo_cnt   (tmo_cnt)
);

// File: tb/tb_rsv_top.sv
module tb_rsv_top;

    localparam int NCH = 4;
    localparam int TW  = 16;
    localparam int WW  = 24;
    localparam int T   = 3;
    localparam int W   = 10;

    logic           clk = 1'b0;
    logic           srst = 1'b1;
    logic           man_rst_n = 1'b1;
    logic           wd_kick = 1'b1;
    logic [NCH-1:0] uv_flag = '0;
    logic [NCH-1:0] ov_flag = '0;
    logic [NCH-1:0] uv_en = '0;
    logic [NCH-1:0] ov_en = '0;
    logic [TW-1:0]  rst_tmo = TW'(T);
    logic [WW-1:0]  wd_tmo = WW'(4000);
    logic           sup_rst_n;
    logic           seq_hold;

    rsv_top #(.NCH(NCH), .TW(TW), .WW(WW)) dut (
        .clk       (clk),
        .srst      (srst),
        .man_rst_n (man_rst_n),
        .wd_kick   (wd_kick),
        .uv_flag   (uv_flag),
        .ov_flag   (ov_flag),
        .uv_en     (uv_en),
        .ov_en     (ov_en),
        .rst_tmo   (rst_tmo),
        .wd_tmo    (wd_tmo),
        .sup_rst_n (sup_rst_n),
        .seq_hold  (seq_hold)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    rn;
        bit    hold;
        string req;
    } exp_t;

    exp_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;

    // monitor: compares queued expectations in the cycle they name
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            n_chk++;
            if (e.at != cyc || sup_rst_n !== e.rn || seq_hold !== e.hold) begin
                n_fail++;
                $display("FAIL %s cycle %0d: sup_rst_n=%b seq_hold=%b, expected %b %b (due cycle %0d)",
                         e.req, cyc, sup_rst_n, seq_hold, e.rn, e.hold, e.at);
            end
        end
    end

    task automatic push(input int at, input bit rn, input bit h, input string req);
        sb.push_back('{at, rn, h, req});
    endtask

    task automatic go_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1..: %0d expectations never checked, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run reached cycle %0d, expected end before 5000", cyc);
        finish_run();
    end

    initial begin
        int c, r, r2, r3, r4;

        // R1: block reset and its stretch
        go_to(3);
        c = cyc;
        srst = 1'b0;
        push(c + 1, 0, 1, "R1");
        push(c + T - 1, 0, 1, "R1");
        push(c + T, 1, 0, "R1");
        go_to(c + T + 2);

        // R2 / R3: multi-cycle manual reset
        c = cyc;
        man_rst_n = 1'b0;
        push(c + 1, 0, 1, "R2");
        push(c + 4, 0, 1, "R2");
        go_to(c + 4);
        man_rst_n = 1'b1;
        push(c + 4 + T - 1, 0, 1, "R3");
        push(c + 4 + T, 1, 0, "R3");
        go_to(c + 4 + T + 2);

        // R3: zero stretch releases one edge later
        c = cyc;
        rst_tmo = '0;
        man_rst_n = 1'b0;
        push(c + 1, 0, 1, "R3");
        push(c + 2, 1, 0, "R3");
        go_to(c + 1);
        man_rst_n = 1'b1;
        go_to(c + 3);
        rst_tmo = TW'(T);

        // R4: retrigger during countdown (also R10: no hold for supply)
        uv_en = 4'b0001;
        c = cyc;
        uv_flag = 4'b0001;
        push(c + 1, 0, 0, "R4");
        push(c + 2, 0, 0, "R4");
        push(c + 5, 0, 0, "R4");
        push(c + 6, 1, 0, "R4");
        go_to(c + 1);
        uv_flag = '0;
        go_to(c + 2);
        uv_flag = 4'b0001;
        go_to(c + 3);
        uv_flag = '0;
        go_to(c + 8);

        // R8: disabled under-voltage channels ignored, enabled one acts
        uv_en = 4'b1000;
        c = cyc;
        uv_flag = 4'b0101;
        push(c + 2, 1, 0, "R8");
        push(c + 4, 1, 0, "R8");
        go_to(c + 4);
        uv_flag = 4'b1000;
        push(c + 5, 0, 0, "R8");
        go_to(c + 5);
        uv_flag = '0;
        push(c + 5 + T, 1, 0, "R8");
        go_to(c + 5 + T + 2);

        // R9: over-voltage uses its own enables
        uv_en = 4'b0001;
        ov_en = 4'b0010;
        c = cyc;
        ov_flag = 4'b0001;
        push(c + 2, 1, 0, "R9");
        push(c + 3, 1, 0, "R9");
        go_to(c + 3);
        ov_flag = 4'b0010;
        push(c + 4, 0, 0, "R9");
        go_to(c + 4);
        ov_flag = '0;
        push(c + 4 + T, 1, 0, "R9");
        go_to(c + 4 + T + 2);
        uv_en = '0;
        ov_en = '0;

        // R6 / R10 / R11: watchdog with no kicks
        c = cyc;
        wd_tmo = WW'(W);
        man_rst_n = 1'b0;
        go_to(c + 1);
        man_rst_n = 1'b1;
        r  = c + 1 + T;
        r2 = r + W + T;
        push(r, 1, 0, "R6");
        push(r + W - 1, 1, 0, "R6");
        push(r + W, 0, 0, "R10");
        push(r2, 1, 0, "R6");
        push(r2 + W - 1, 1, 0, "R11");
        push(r2 + W, 0, 0, "R11");
        r3 = r2 + W + T;
        go_to(r3);

        // R7: kick held low counts only its falling edge
        wd_kick = 1'b0;
        push(r3 + W, 1, 0, "R7");
        push(r3 + 1 + W, 0, 0, "R7");
        r4 = r3 + 1 + W + T;
        push(r4, 1, 0, "R7");
        go_to(r3 + W + 2);
        wd_kick = 1'b1;
        go_to(r4);

        // R5: regular kicks keep the reset released
        push(r4 + 10, 1, 0, "R5");
        push(r4 + 25, 1, 0, "R5");
        push(r4 + 41, 1, 0, "R5");
        for (int k = 0; k < 7; k++) begin
            wd_kick = 1'b0;
            go_to(cyc + 3);
            wd_kick = 1'b1;
            go_to(cyc + 3);
        end
        wd_tmo = WW'(4000);
        go_to(cyc + 5);
        finish_run();
    end

endmodule